// File: doc/BRIEF.md
# Prescaled Event Timer with Compare-Driven Reset

A 16-bit up-counter advanced by a power-of-two prescaler (divide by 1, 2, 4 or 8). Its count source is either every system clock cycle or the rising edges of an external clock. The external clock is brought into the system domain by a synchronizer, and its edges are detected there. Software reaches the counter through byte-wide registers. The upper byte is staged in a holding register and enters the counter only together with the lower byte. Reading the lower byte freezes a copy of the upper byte, so a 16-bit value taken with two reads is coherent.

A 16-bit compare value sits next to the counter. A combinational match flag reports equality. In event-reset mode, the counter returns to zero on the first prescaler output pulse after it has reached the compare value, so the period is compare value plus one prescaled counts. A one-cycle trigger pulse marks each such reset. Wrapping from all ones to zero sets a sticky overflow flag that software clears by a write. When the counter is started, or when its low byte is written, the external source must show a falling edge before any rising edge counts.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter is 0x0000, the overflow flag is 0 and the trigger output is 0.
- R2: The prescale select picks the divide ratio as 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. With N source ticks after a start from a cleared prescaler, the counter advances by N divided by the ratio, rounded down. The prescaler is held cleared while run_en is low.
- R3: A write to address 1 (high byte) only loads a holding register and leaves the counter and the prescaler untouched. A write to address 0 loads the counter with {holding register, data} and takes priority over an increment in that cycle.
- R4: Reading address 0 returns the counter's low byte and latches the counter's high byte. Reading address 1 returns that latched byte, whatever the counter has done since.
- R5: An increment from 0xFFFF to 0x0000 sets the overflow flag, read as bit 0 of address 2. The flag stays set until a write to address 2 clears it. A set in the same cycle wins over the clear.
- R6: match_o is high whenever the counter equals cmp_val. In event-reset mode, a prescaler pulse arriving while the counter equals cmp_val loads 0 instead of incrementing. Until that pulse arrives, the counter holds the compare value.
- R7: trig_o is high for exactly the one cycle that follows each event reset, and the counter reads 0 in that cycle.
- R8: With clk_sel high, each rising edge of ext_clk is counted once, provided each level lasts at least one system cycle. A period of two system cycles counts every edge, and a wrap in this mode sets the overflow flag.
- R9: After run_en rises, or after a low-byte write, rising edges of ext_clk are ignored until a falling edge has been seen.
- R10: The event reset of R6 also works when the counter runs from the external clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enabled when high |
| clk_sel | input | 1 | 0: system clock ticks, 1: external clock edges |
| ext_clk | input | 1 | External count clock, asynchronous |
| pre_sel | input | 2 | Prescale select (ratio 1, 2, 4, 8) |
| evt_mode | input | 1 | Event-reset mode enable |
| cmp_val | input | 16 | Compare value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low byte, 1 high byte, 2 overflow clear |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | 0 low byte, 1 latched high byte, 2 overflow flag |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| match_o | output | 1 | Counter equals cmp_val |
| trig_o | output | 1 | One-cycle event-reset pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A system tick that completes a prescale group changes the counter at that same clock edge, so after N edges with run_en high the bench expects exactly N divided by the ratio. An external rising edge passes two synchronizer stages and one edge-detect stage, and it shows in the counter on the third system edge after it is driven. For that reason the bench waits several cycles after the last external edge before it stops the counter. The trigger is registered and is sampled in the cycle after the edge that performs the event reset. match_o and rd_data are combinational and are read half a cycle after the inputs change, with the counter stopped so that no edge intervenes.

// File: rtl/evt_timer_pkg.sv
// Shared definitions for the event timer: register address map.
package evt_timer_pkg;
    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_timer_extedge.sv
// External clock synchronizer and armed rising-edge detector.
// Assumes ext_clk levels last at least one clk cycle. A rising edge is
// reported only after a falling edge has been seen since the last restart.
module evt_timer_extedge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic restart,
    output logic rise_o
);
    logic [SYNC_STAGES:0] sh_q;
    logic                 armed_q;
    logic                 lvl, prv, rise, fall;

    assign lvl  = sh_q[SYNC_STAGES-1];
    assign prv  = sh_q[SYNC_STAGES];
    assign rise = lvl & ~prv;
    assign fall = ~lvl & prv;

    // Shift the external level through the synchronizer plus history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk};
    end

    // Arm on a falling edge; disarm on every restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (restart) armed_q <= 1'b0;
        else if (fall)    armed_q <= 1'b1;
    end

    assign rise_o = rise & armed_q;

    AST_NO_RISE_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !rise_o); // R9
endmodule

// File: rtl/evt_timer_presc.sv
// Power-of-two prescaler: one pulse per 2**sel ticks.
// Assumes sel is steady while enabled; the count is cleared while disabled.
module evt_timer_presc #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic [PS_W-1:0] sel,
    output logic            pulse_o
);
    localparam int DIV_W = (1 << PS_W) - 1;
    localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W:0]   lim;
    logic             last;

    assign lim     = (ONE << sel) - ONE;
    assign last    = ({1'b0, pre_q} >= lim);
    assign pulse_o = tick & last;

    // Count ticks within the current group; clear at group end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) pre_q <= '0;
        else if (tick)         pre_q <= last ? '0 : pre_q + 1'b1;
    end

    AST_PRESC_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && !pulse_o) |=> (pre_q != '0)); // R2
endmodule

// File: rtl/evt_timer_core.sv
// Counter register with buffered high-byte load, coherent read latch,
// sticky overflow and compare-driven event reset.
// Assumes at most one of wr_lo, wr_hi, wr_clr is high in a cycle.
module evt_timer_core #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              evt_mode,
    input  logic [2*BYTE_W-1:0] cmp_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_clr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_lo,
    output logic [2*BYTE_W-1:0] count_o,
    output logic [BYTE_W-1:0] rd_hi_o,
    output logic              ovf_o,
    output logic              match_o,
    output logic              trig_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hold_q, rdhi_q;
    logic              ovf_q, trig_q, hit, evt_rst, wrap;

    assign hit     = (cnt_q == cmp_val);
    assign evt_rst = inc & evt_mode & hit & ~wr_lo;
    assign wrap    = inc & ~wr_lo & ~evt_rst & (&cnt_q);

    // Counter: low-byte write loads, event reset clears, pulse increments.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_lo)   cnt_q <= {hold_q, wr_data};
        else if (evt_rst) cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    // Holding register for the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_hi) hold_q <= wr_data;
    end

    // Read latch of the high byte, taken on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdhi_q <= '0;
        else if (rd_lo) rdhi_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    // Sticky overflow flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovf_q <= 1'b0;
        else if (wrap)   ovf_q <= 1'b1;
        else if (wr_clr) ovf_q <= 1'b0;
    end

    // One-cycle trigger after each event reset.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= evt_rst;
    end

    assign count_o = cnt_q;
    assign rd_hi_o = rdhi_q;
    assign ovf_o   = ovf_q;
    assign match_o = hit;
    assign trig_o  = trig_q;

    AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> (cnt_q == '0)); // R7
    AST_HIGH_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !inc) |=> $stable(cnt_q)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !wr_clr) |=> ovf_q); // R5
    AST_MATCH_WAITS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mode && hit && !inc && !wr_lo) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/evt_timer.sv
// Top of the prescaled event timer: source select, prescaler, counter core
// and byte register access. Assumes one register write per cycle.
module evt_timer #(
    parameter int BYTE_W      = 8,
    parameter int PS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                clk_sel,
    input  logic                ext_clk,
    input  logic [PS_W-1:0]     pre_sel,
    input  logic                evt_mode,
    input  logic [2*BYTE_W-1:0] cmp_val,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [1:0]          rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                match_o,
    output logic                trig_o,
    output logic                ovf_o
);
    import evt_timer_pkg::*;
    localparam int CNT_W = 2 * BYTE_W;

    reg_sel_e         wsel, rsel;
    logic             run_q, restart, ext_rise, tick, pulse;
    logic             wr_lo, wr_hi, wr_clr, rd_lo;
    logic [CNT_W-1:0] count;
    logic [BYTE_W-1:0] rd_hi;

    assign wsel   = reg_sel_e'(wr_addr);
    assign rsel   = reg_sel_e'(rd_addr);
    assign wr_lo  = wr_en & (wsel == REG_LO);
    assign wr_hi  = wr_en & (wsel == REG_HI);
    assign wr_clr = wr_en & (wsel == REG_FLAG);
    assign rd_lo  = rd_en & (rsel == REG_LO);

    // Remember run_en to detect a start.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end

    assign restart = (run_en & ~run_q) | wr_lo;
    assign tick    = run_en & (clk_sel ? ext_rise : 1'b1);

    evt_timer_extedge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .restart(restart), .rise_o(ext_rise)
    );

    evt_timer_presc #(.PS_W(PS_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .enable(run_en),
        .tick(tick), .sel(pre_sel), .pulse_o(pulse)
    );

    evt_timer_core #(.BYTE_W(BYTE_W)) core_i (
        .clk(clk), .rst_n(rst_n), .inc(pulse), .evt_mode(evt_mode),
        .cmp_val(cmp_val), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_clr(wr_clr),
        .wr_data(wr_data), .rd_lo(rd_lo), .count_o(count), .rd_hi_o(rd_hi),
        .ovf_o(ovf_o), .match_o(match_o), .trig_o(trig_o)
    );

    // Read data selection by address.
    always_comb begin
        unique case (rsel)
            REG_LO:   rd_data = count[BYTE_W-1:0];
            REG_HI:   rd_data = rd_hi;
            REG_FLAG: rd_data = {{(BYTE_W-1){1'b0}}, ovf_o};
            default:  rd_data = '0;
        endcase
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_lo) |=> $stable(count)); // R2
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, clk_sel = 1'b0, ext_clk = 1'b0, evt_mode = 1'b0;
    logic [1:0]  pre_sel = 2'd0;
    logic [15:0] cmp_val = 16'h0100;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        match_o, trig_o, ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    evt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_sel(clk_sel),
        .ext_clk(ext_clk), .pre_sel(pre_sel), .evt_mode(evt_mode),
        .cmp_val(cmp_val), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .match_o(match_o), .trig_o(trig_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load16(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    task automatic run_edges(input int n);
        @(negedge clk); run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic ext_cycle(input int half);
        @(negedge clk); ext_clk = 1'b1;
        repeat (half) @(negedge clk);
        ext_clk = 1'b0;
        repeat (half - 1) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d); chk("R1 count low", d, 8'h00);
        rd(2'd2, d); chk("R1 overflow flag", d, 8'h00);
        chk("R1 trigger", trig_o, 1'b0);
    endtask

    task automatic t_buffered;
        logic [15:0] v;
        wr(2'd1, 8'hAB);
        rd16(v); chk("R3 high write alone", v, 16'h0000);
        wr(2'd0, 8'hCD);
        rd16(v); chk("R3 low write commits", v, 16'hABCD);
        load16(16'h0000);
        pre_sel = 2'd2;
        @(negedge clk); run_en = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        repeat (5) @(negedge clk);
        run_en = 1'b0;
        rd16(v); chk("R3 interval not stretched", v, 16'h0002);
        pre_sel = 2'd0;
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        for (int s = 0; s < 4; s++) begin
            pre_sel = s[1:0];
            load16(16'h0000);
            run_edges(20);
            rd16(v); chk("R2 prescale ratio", v, 16'(20 >> s));
        end
        pre_sel = 2'd0;
    endtask

    task automatic t_coherent;
        logic [7:0] d;
        load16(16'h12FF);
        rd(2'd0, d); chk("R4 low byte", d, 8'hFF);
        run_edges(1);
        rd(2'd1, d); chk("R4 latched high", d, 8'h12);
        rd(2'd0, d); chk("R4 new low", d, 8'h00);
        rd(2'd1, d); chk("R4 relatch high", d, 8'h13);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        logic [7:0]  d;
        load16(16'hFFFE);
        run_edges(2);
        rd(2'd2, d); chk("R5 flag set on wrap", d, 8'h01);
        run_edges(3);
        rd(2'd2, d); chk("R5 flag sticky", d, 8'h01);
        rd16(v); chk("R5 count after wrap", v, 16'h0003);
        wr(2'd2, 8'h00);
        rd(2'd2, d); chk("R5 flag cleared", d, 8'h00);
    endtask

    task automatic t_event;
        logic [15:0] v;
        cmp_val = 16'd5; pre_sel = 2'd1; evt_mode = 1'b1;
        load16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 match at compare", match_o, 1'b1);
        @(negedge clk);
        chk("R6 no early reset", match_o, 1'b1);
        chk("R7 no early trigger", trig_o, 1'b0);
        @(negedge clk);
        chk("R7 trigger after reset", trig_o, 1'b1);
        chk("R6 match gone", match_o, 1'b0);
        @(negedge clk);
        chk("R7 trigger one cycle", trig_o, 1'b0);
        run_en = 1'b0;
        rd16(v); chk("R6 count reset to zero", v, 16'h0000);
        evt_mode = 1'b0; pre_sel = 2'd0; cmp_val = 16'h0100;
    endtask

    task automatic t_external;
        logic [15:0] v;
        logic [7:0]  d;
        clk_sel = 1'b1;
        load16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        ext_cycle(2);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        rd16(v); chk("R9 first rise ignored", v, 16'h0000);
        load16(16'hFFFE);
        @(negedge clk); run_en = 1'b1;
        ext_cycle(1);
        for (int i = 0; i < 4; i++) ext_cycle(1);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        rd16(v); chk("R8 fast external count", v, 16'h0002);
        rd(2'd2, d); chk("R8 external wrap flag", d, 8'h01);
        wr(2'd2, 8'h00);
        cmp_val = 16'd3; evt_mode = 1'b1;
        load16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        ext_cycle(2);
        for (int i = 0; i < 5; i++) ext_cycle(2);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        rd16(v); chk("R10 external event reset", v, 16'h0001);
        evt_mode = 1'b0; clk_sel = 1'b0; cmp_val = 16'h0100;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_buffered();
        t_prescale();
        t_coherent();
        t_overflow();
        t_event();
        t_external();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule